// File: doc/BRIEF.md
# Register Transfer and Stack Unit

This block carries out the one-byte register moves and stack operations of an 8-bit processor core. An opcode strobe starts one instruction. The block then moves a byte between the accumulator, the two index registers and the stack pointer, or it pushes or pulls the accumulator or the status byte through a byte-wide memory port. All stack traffic is confined to one fixed page.

The instruction fetch path presents the opcode with a one-cycle strobe while the unit is idle, and it waits for the done pulse before it sends the next one. The register file lives inside the unit and is visible at its outputs. Opcodes outside the supported set produce an error pulse and leave every register as it was.

The status byte uses this layout: N bit 7, V bit 6, D bit 3, I bit 2, Z bit 1 and C bit 0. Bits 5 and 4 always read as 1.

Top module: `xfer_stack_unit`

## Requirements
- R1: After reset, A, X and Y are 0x00, S is 0xFF, P is 0x34 and done is low.
- R2: TAX (0xAA), TAY (0xA8), TXA (0x8A) and TYA (0x98) copy the source register into the destination, set N to bit 7 and Z to (byte == 0), keep every other flag, and take 2 cycles.
- R3: TXS (0x9A) copies X into S in 2 cycles and leaves P unchanged.
- R4: PHA (0x48) and PHP (0x08) write one byte at address 0x0100+S, then decrement S modulo 256, take 3 cycles and change no flag. PHA writes A. PHP writes P with bits 5 and 4 set.
- R5: PLA (0x68) and PLP (0x28) first increment S modulo 256, then read address 0x0100+S, and take 4 cycles. The read data is taken one cycle after the read strobe.
- R6: PLA loads A from the pulled byte and sets N and Z from it. PLP loads N, V, D, I, Z and C from bits 7, 6, 3, 2, 1 and 0 of the pulled byte and ignores its bits 5 and 4.
- R7: done is high for exactly one cycle, which is the last cycle of the instruction. The strobe cycle counts as cycle 1.
- R8: A strobe with any other opcode raises illegal for exactly one cycle, on the cycle after the strobe. It raises no done, issues no memory access and changes no register.
- R9: A strobe that arrives while an instruction is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Opcode strobe |
| op_code | input | 8 | Opcode byte |
| mem_addr | output | 16 | Stack address, 0x0100+S |
| mem_wdata | output | 8 | Byte to push |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe; data is expected on the next cycle |
| mem_rdata | input | 8 | Read data |
| a_q | output | 8 | Accumulator |
| x_q | output | 8 | X index register |
| y_q | output | 8 | Y index register |
| s_q | output | 8 | Stack pointer |
| p_q | output | 8 | Status byte |
| done | output | 1 | Last-cycle pulse of a legal instruction |
| illegal | output | 1 | Unsupported-opcode pulse |

## Verification
The bench builds the unit with its default parameters: the stack sits on page 0x01 and S resets to 0xFF. With these values a push from S = 0x00 and a pull from S = 0xFF reach the wrap of the stack pointer within a few instructions. Loading 0xFF and 0x00 through PLP drives every status bit to both values, which shows the forced bits 5 and 4 at both ends. A long random run mixes all nine opcodes with unsupported ones, so every instruction follows every other one and flag history carries over between them.

// File: rtl/xfer_pkg.sv
// Shared types for the transfer/stack unit: decoded operation kinds
// and the bit positions of the status byte.
package xfer_pkg;
    typedef enum logic [3:0] {
        K_TAX, K_TAY, K_TXA, K_TYA, K_TXS,
        K_PHA, K_PHP, K_PLA, K_PLP, K_BAD
    } op_kind_e;

    localparam int P_N = 7;
    localparam int P_V = 6;
    localparam int P_U = 5;
    localparam int P_B = 4;
    localparam int P_D = 3;
    localparam int P_I = 2;
    localparam int P_Z = 1;
    localparam int P_C = 0;
endpackage

// File: rtl/xfer_decode.sv
// Opcode decoder. Purely combinational: maps an opcode byte to an
// operation kind and its total cycle count (strobe cycle included).
// Assumes nothing about timing; unknown bytes map to K_BAD.
module xfer_decode
    import xfer_pkg::*;
#(
    parameter int OP_W  = 8,
    parameter int CNT_W = 3
) (
    input  logic [OP_W-1:0]  opcode,
    output op_kind_e         kind,
    output logic [CNT_W-1:0] total
);
    // Opcode table lookup.
    always_comb begin
        kind  = K_BAD;
        total = CNT_W'(2);
        case (opcode)
            8'hAA: kind = K_TAX;
            8'hA8: kind = K_TAY;
            8'h8A: kind = K_TXA;
            8'h98: kind = K_TYA;
            8'h9A: kind = K_TXS;
            8'h48: begin kind = K_PHA; total = CNT_W'(3); end
            8'h08: begin kind = K_PHP; total = CNT_W'(3); end
            8'h68: begin kind = K_PLA; total = CNT_W'(4); end
            8'h28: begin kind = K_PLP; total = CNT_W'(4); end
            default: kind = K_BAD;
        endcase
    end
endmodule

// File: rtl/xfer_seq.sv
// Instruction sequencer. Accepts a decoded strobe while idle, then counts
// cycles 2..total and flags the last one with done. Rejected opcodes give
// a one-cycle illegal pulse on the following cycle. Strobes while busy are
// dropped. Assumes the decoder's total is at least 2.
module xfer_seq
    import xfer_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  op_kind_e         kind_in,
    input  logic [CNT_W-1:0] total_in,
    output logic             busy,
    output op_kind_e         kind_q,
    output logic [CNT_W-1:0] step,
    output logic             done,
    output logic             illegal
);
    logic [CNT_W-1:0] total_q;
    logic             accept;

    // Start condition: idle, strobed and recognised.
    assign accept = op_valid && !busy && (kind_in != K_BAD);
    // Last-cycle flag.
    assign done   = busy && (step == total_q);

    // Cycle counter, captured kind and illegal pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            step    <= '0;
            total_q <= '0;
            kind_q  <= K_TAX;
            illegal <= 1'b0;
        end else begin
            illegal <= op_valid && !busy && (kind_in == K_BAD);
            if (accept) begin
                busy    <= 1'b1;
                step    <= CNT_W'(2);
                kind_q  <= kind_in;
                total_q <= total_in;
            end else if (done) begin
                busy <= 1'b0;
            end else if (busy) begin
                step <= step + 1'b1;
            end
        end
    end

    // R7: done lasts one cycle.
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8: an illegal pulse never coincides with a running instruction.
    a_r8_illegal_idle: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!busy && !done));
    // R9: an instruction in progress keeps its kind until done.
    a_r9_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> (busy && $stable(kind_q)));
endmodule

// File: rtl/xfer_regs.sv
// Register file and stack datapath. Holds A, X, Y, S and P and performs
// the step actions the sequencer selects. Pushes write at cycle 2 and
// decrement S at cycle 3. Pulls increment S at cycle 2, read at cycle 3
// and load at cycle 4. Assumes the memory returns read data one cycle
// after mem_re.
module xfer_regs
    import xfer_pkg::*;
#(
    parameter int              DATA_W     = 8,
    parameter int              CNT_W      = 3,
    parameter logic [DATA_W-1:0] STACK_PAGE = 8'h01,
    parameter logic [DATA_W-1:0] RESET_SP   = 8'hFF,
    parameter logic [DATA_W-1:0] RESET_P    = 8'h34,
    localparam int             ADDR_W     = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  op_kind_e          kind_q,
    input  logic [CNT_W-1:0]  step,
    input  logic              done,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    output logic [DATA_W-1:0] a_q,
    output logic [DATA_W-1:0] x_q,
    output logic [DATA_W-1:0] y_q,
    output logic [DATA_W-1:0] s_q,
    output logic [DATA_W-1:0] p_q
);
    localparam logic [DATA_W-1:0] FIXED_ONES = DATA_W'(8'h30);
    localparam logic [DATA_W-1:0] LOAD_MASK  = DATA_W'(8'hCF);

    logic is_push, is_pull;

    // Status byte with N and Z taken from a moved byte.
    function automatic logic [DATA_W-1:0] with_nz(input logic [DATA_W-1:0] p,
                                                  input logic [DATA_W-1:0] v);
        logic [DATA_W-1:0] r;
        r      = p;
        r[P_N] = v[DATA_W-1];
        r[P_Z] = (v == '0);
        return r;
    endfunction

    // Operation class decode.
    assign is_push = (kind_q == K_PHA) || (kind_q == K_PHP);
    assign is_pull = (kind_q == K_PLA) || (kind_q == K_PLP);

    // Memory port: always points at the stack slot.
    assign mem_addr  = {STACK_PAGE, s_q};
    assign mem_we    = busy && is_push && (step == CNT_W'(2));
    assign mem_re    = busy && is_pull && (step == CNT_W'(3));
    assign mem_wdata = (kind_q == K_PHP) ? (p_q | FIXED_ONES) : a_q;

    // Register updates per operation step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= '0;
            x_q <= '0;
            y_q <= '0;
            s_q <= RESET_SP;
            p_q <= RESET_P | FIXED_ONES;
        end else if (busy) begin
            case (kind_q)
                K_TAX: if (done) begin x_q <= a_q; p_q <= with_nz(p_q, a_q); end
                K_TAY: if (done) begin y_q <= a_q; p_q <= with_nz(p_q, a_q); end
                K_TXA: if (done) begin a_q <= x_q; p_q <= with_nz(p_q, x_q); end
                K_TYA: if (done) begin a_q <= y_q; p_q <= with_nz(p_q, y_q); end
                K_TXS: if (done) s_q <= x_q;
                K_PHA, K_PHP: if (step == CNT_W'(3)) s_q <= s_q - 1'b1;
                K_PLA: begin
                    if (step == CNT_W'(2)) s_q <= s_q + 1'b1;
                    if (step == CNT_W'(4)) begin
                        a_q <= mem_rdata;
                        p_q <= with_nz(p_q, mem_rdata);
                    end
                end
                K_PLP: begin
                    if (step == CNT_W'(2)) s_q <= s_q + 1'b1;
                    if (step == CNT_W'(4)) p_q <= (mem_rdata & LOAD_MASK) | FIXED_ONES;
                end
                default: ;
            endcase
        end
    end

    // R3: TXS never touches the flags.
    a_r3_txs_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && kind_q == K_TXS) |=> $stable(p_q));
    // R2: after TAX, Z and N describe the new X.
    a_r2_tax_nz: assert property (@(posedge clk) disable iff (!rst_n)
        (done && kind_q == K_TAX) |=> ((p_q[P_Z] == (x_q == '0)) && (p_q[P_N] == x_q[DATA_W-1])));
    // R4: pushes leave A and P alone.
    a_r4_push_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && is_push) |=> ($stable(p_q) && $stable(a_q)));
    // R5: a pull reads exactly once and never writes at the same time.
    a_r5_single_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> !mem_re);
    a_r5_no_rw: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_re && mem_we));
endmodule

// File: rtl/xfer_stack_unit.sv
// Top of the register transfer and stack unit: decoder, sequencer and
// register datapath. Assumes op_valid is only a strobe; the caller waits
// for done or illegal before issuing the next opcode.
module xfer_stack_unit
    import xfer_pkg::*;
#(
    parameter int                DATA_W     = 8,
    parameter logic [DATA_W-1:0] STACK_PAGE = 8'h01,
    parameter logic [DATA_W-1:0] RESET_SP   = 8'hFF,
    localparam int               ADDR_W     = 2 * DATA_W,
    localparam int               CNT_W      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [7:0]        op_code,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] a_q,
    output logic [DATA_W-1:0] x_q,
    output logic [DATA_W-1:0] y_q,
    output logic [DATA_W-1:0] s_q,
    output logic [DATA_W-1:0] p_q,
    output logic              done,
    output logic              illegal
);
    op_kind_e         dec_kind, run_kind;
    logic [CNT_W-1:0] dec_total, run_step;
    logic             run_busy;

    xfer_decode #(.OP_W(8), .CNT_W(CNT_W)) u_decode (
        .opcode (op_code),
        .kind   (dec_kind),
        .total  (dec_total)
    );

    xfer_seq #(.CNT_W(CNT_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_valid (op_valid),
        .kind_in  (dec_kind),
        .total_in (dec_total),
        .busy     (run_busy),
        .kind_q   (run_kind),
        .step     (run_step),
        .done     (done),
        .illegal  (illegal)
    );

    xfer_regs #(
        .DATA_W     (DATA_W),
        .CNT_W      (CNT_W),
        .STACK_PAGE (STACK_PAGE),
        .RESET_SP   (RESET_SP)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy      (run_busy),
        .kind_q    (run_kind),
        .step      (run_step),
        .done      (done),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_re    (mem_re),
        .a_q       (a_q),
        .x_q       (x_q),
        .y_q       (y_q),
        .s_q       (s_q),
        .p_q       (p_q)
    );
endmodule

// File: tb/xfer_stack_unit_bench.sv
// Self-checking bench: directed corners plus seeded random opcode mix,
// compared against a register model kept in bench functions.
module xfer_stack_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [7:0]  op_code = 8'h00;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic        mem_we, mem_re;
    logic [7:0]  a_q, x_q, y_q, s_q, p_q;
    logic        done, illegal;

    logic [7:0]  stk [256];
    logic        poke_en = 1'b0;
    logic [7:0]  poke_addr = 8'h00, poke_data = 8'h00;

    int tests = 0;
    int fails = 0;
    logic [7:0] ma = 8'h00, mx = 8'h00, my = 8'h00, ms = 8'hFF, mp = 8'h34;

    always #4 clk = ~clk;

    xfer_stack_unit u_xfer_stack_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .mem_re(mem_re), .mem_rdata(mem_rdata),
        .a_q(a_q), .x_q(x_q), .y_q(y_q), .s_q(s_q), .p_q(p_q),
        .done(done), .illegal(illegal)
    );

    // Page-one memory with registered read.
    always @(posedge clk) begin
        if (poke_en) stk[poke_addr] <= poke_data;
        if (mem_we && mem_addr[15:8] == 8'h01) stk[mem_addr[7:0]] <= mem_wdata;
        if (mem_re) mem_rdata <= (mem_addr[15:8] == 8'h01) ? stk[mem_addr[7:0]] : 8'hXX;
    end

    function automatic logic [7:0] nz(input logic [7:0] p, input logic [7:0] v);
        logic [7:0] r;
        r = p; r[7] = v[7]; r[1] = (v == 8'h00);
        return r;
    endfunction

    function automatic int op_len(input logic [7:0] op);
        case (op)
            8'hAA, 8'hA8, 8'h8A, 8'h98, 8'h9A: return 2;
            8'h48, 8'h08: return 3;
            8'h68, 8'h28: return 4;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic chk_regs(input string req);
        chk(req, "A", {8'h00, a_q}, {8'h00, ma});
        chk(req, "X", {8'h00, x_q}, {8'h00, mx});
        chk(req, "Y", {8'h00, y_q}, {8'h00, my});
        chk(req, "S", {8'h00, s_q}, {8'h00, ms});
        chk(req, "P", {8'h00, p_q}, {8'h00, mp});
    endtask

    // Runs one opcode from a negedge; pull_byte is placed at the slot a pull reads.
    task automatic do_op(input logic [7:0] op, input logic [7:0] pull_byte);
        int len, n;
        logic [7:0] paddr, pbyte;
        string req;
        len = op_len(op);
        req = "R2";
        paddr = ms; pbyte = 8'h00;
        case (op)
            8'hAA: begin mx = ma; mp = nz(mp, ma); end
            8'hA8: begin my = ma; mp = nz(mp, ma); end
            8'h8A: begin ma = mx; mp = nz(mp, mx); end
            8'h98: begin ma = my; mp = nz(mp, my); end
            8'h9A: begin ms = mx; req = "R3"; end
            8'h48: begin pbyte = ma; ms = ms - 8'd1; req = "R4"; end
            8'h08: begin pbyte = mp | 8'h30; ms = ms - 8'd1; req = "R4"; end
            8'h68: begin ms = ms + 8'd1; ma = pull_byte; mp = nz(mp, pull_byte); req = "R6"; end
            8'h28: begin ms = ms + 8'd1; mp = (pull_byte & 8'hCF) | 8'h30; req = "R6"; end
            default: req = "R8";
        endcase
        if (op == 8'h68 || op == 8'h28) begin
            poke_en = 1'b1; poke_addr = ms; poke_data = pull_byte;
        end
        op_valid = 1'b1; op_code = op;
        @(negedge clk);
        op_valid = 1'b0; poke_en = 1'b0;
        if (len == 0) begin
            chk("R8", "illegal pulse", {15'h0, illegal}, 16'h1);
            chk("R8", "no done", {15'h0, done}, 16'h0);
            @(negedge clk);
            chk("R8", "illegal width", {15'h0, illegal}, 16'h0);
            chk_regs("R8");
            return;
        end
        n = 2;
        while (!done && n < 8) begin
            chk("R5", "no access off-step", {15'h0, mem_we & mem_re}, 16'h0);
            @(negedge clk);
            n++;
        end
        chk("R7", "cycle count", 16'(n), 16'(len));
        @(negedge clk);
        chk("R7", "done single", {15'h0, done}, 16'h0);
        chk_regs(req);
        if (len == 3) chk("R4", "pushed byte", {8'h00, stk[paddr]}, {8'h00, pbyte});
    endtask

    // Global watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] ops [9];
        logic [7:0] op;
        ops = '{8'hAA, 8'hA8, 8'h8A, 8'h98, 8'h9A, 8'h48, 8'h08, 8'h68, 8'h28};
        void'($urandom(32'h5EED));
        for (int i = 0; i < 256; i++) stk[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk_regs("R1");
        chk("R1", "done", {15'h0, done}, 16'h0);

        // R6/R2 directed: zero and negative bytes through A, X, Y
        do_op(8'h68, 8'h00);
        do_op(8'hAA, 8'h00);
        do_op(8'h68, 8'h80);
        do_op(8'hA8, 8'h00);
        do_op(8'h8A, 8'h00);
        do_op(8'h98, 8'h00);
        // R3 TXS with X = 0, then R4 push wrap from S = 0x00
        do_op(8'h9A, 8'h00);
        do_op(8'h48, 8'h00);
        chk("R4", "wrap S", {8'h00, s_q}, 16'h00FF);
        // R5 pull wrap from S = 0xFF reads slot 0x00
        do_op(8'h68, 8'h5A);
        chk("R5", "wrap S", {8'h00, s_q}, 16'h0000);
        // R6 PLP all ones and all zeros; R4 PHP forced bits
        do_op(8'h28, 8'hFF);
        do_op(8'h08, 8'h00);
        do_op(8'h28, 8'h00);
        chk("R6", "P after PLP 00", {8'h00, p_q}, 16'h0030);
        do_op(8'h08, 8'h00);
        // R8 illegal opcodes
        do_op(8'hEA, 8'h00);
        do_op(8'h00, 8'h00);
        // R9 strobe held during a pull is ignored
        op_valid = 1'b1; op_code = 8'h68;
        poke_en = 1'b1; poke_addr = ms + 8'd1; poke_data = 8'h11;
        @(negedge clk);
        poke_en = 1'b0; op_code = 8'hAA;
        ms = ms + 8'd1; ma = 8'h11; mp = nz(mp, 8'h11);
        while (!done) @(negedge clk);
        op_valid = 1'b0;
        @(negedge clk);
        chk_regs("R9");
        @(negedge clk);
        chk("R9", "X untouched", {8'h00, x_q}, {8'h00, mx});

        // Random mix
        for (int k = 0; k < 400; k++) begin
            if ($urandom_range(0, 9) == 0) begin
                op = 8'($urandom_range(0, 255));
                while (op_len(op) != 0) op = op + 8'd1;
            end else begin
                op = ops[$urandom_range(0, 8)];
            end
            do_op(op, 8'($urandom_range(0, 255)));
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule